// File: doc/BRIEF.md
# Block DMA Controller

This block copies a run of words between a single peripheral and memory so the processor does not have to move each word itself. Software sets up the job through four register slots. It gives the first memory address, the number of words and which way the data flows, and then issues a go command in a separate write. From that point the controller runs both bus sides on its own, one word at a time. For every word it completes one handshake with memory and one with the peripheral, in the order set by the direction.

After the last word the controller returns to idle and raises an interrupt line. The line stays high until software acknowledges it. A job with a length of zero finishes at once and touches neither bus. While a job is running, the configuration is locked against writes, so software cannot change a transfer that is in progress.

Top module: `dma_block_mover`

## Requirements
- R1: After reset the controller is idle: `irq`, `mem_req` and `dev_req` are 0, and every register slot reads 0.
- R2: Slot 0 holds the start address (the low AW bits), slot 1 holds the word count (the low CW bits) and bit 0 of slot 2 holds the direction (0 means memory to peripheral, 1 means peripheral to memory). Reads return the written values, zero-extended.
- R3: Writing slot 3 with bit 0 set, while idle and with a nonzero count, sets busy (slot 3 read bit 0) and starts bus activity on the following cycle. Programming the other slots alone never causes bus activity.
- R4: In memory-to-peripheral mode each word is first read from memory (`mem_req`=1, `mem_we`=0) and then written to the peripheral (`dev_req`=1, `dev_wr`=1) with the data the memory returned.
- R5: In peripheral-to-memory mode each word is first fetched from the peripheral (`dev_req`=1, `dev_wr`=0) and then written to memory (`mem_req`=1, `mem_we`=1) with the data the peripheral returned.
- R6: Word k of a job uses memory address base + k*ADDR_STEP, taken modulo 2^AW.
- R7: Exactly count words are moved. In the cycle after the final acknowledge, busy drops and `irq` (also slot 3 read bit 1) rises.
- R8: A go command with a count of 0 sets `irq` on the next cycle. No request is issued and busy stays 0.
- R9: While busy, writes to slots 0 to 2 are ignored and a further go command is ignored.
- R10: `irq` stays high until slot 3 is written with bit 1 set, and it reads 0 from the next cycle on. If a completion occurs in the same cycle as an acknowledge, the completion wins.
- R11: `mem_req` and `dev_req` are never high together. Each request, together with its address, write flag and write data, is held steady until its acknowledge is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register slot select |
| csr_wdata | input | DW | Register write data |
| csr_rdata | output | DW | Read data for the selected slot (combinational) |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Data to memory |
| mem_rdata | input | DW | Data from memory, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| dev_req | output | 1 | Peripheral request |
| dev_wr | output | 1 | Peripheral write (1) or fetch (0) |
| dev_wdata | output | DW | Data to peripheral |
| dev_rdata | input | DW | Data from peripheral, valid with `dev_ack` |
| dev_ack | input | 1 | Peripheral acknowledge, one cycle |

## Verification
The bench builds the block with AW=16, DW=16, CW=4 and ADDR_STEP=4. A 4-bit count makes the largest possible job of 15 words short enough to run in full. A 16-bit address lets a job start at 0xFFF8 and wrap past zero within a few words. A step of 4 selects the variant that increments only the upper address bits. The responders use different acknowledge latencies, so the hold behaviour of each request is exercised under both short and long waits.

// File: rtl/dma_pkg.sv
package dma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MEM_FETCH,
      ST_DEV_PUT,
      ST_DEV_FETCH,
      ST_MEM_PUT
   } xfer_state_e;

   localparam logic [1:0] SEL_BASE = 2'd0;
   localparam logic [1:0] SEL_LEN  = 2'd1;
   localparam logic [1:0] SEL_MODE = 2'd2;
   localparam logic [1:0] SEL_CMD  = 2'd3;

   localparam int CMD_GO_BIT    = 0;
   localparam int CMD_ACK_BIT   = 1;
   localparam int STAT_BUSY_BIT = 0;
   localparam int STAT_IRQ_BIT  = 1;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
   import dma_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          csr_we,
   input  logic [1:0]    csr_sel,
   input  logic [DW-1:0] csr_wdata,
   output logic [DW-1:0] csr_rdata,
   input  logic          busy,
   input  logic          finish,
   output logic          go,
   output logic [AW-1:0] go_base,
   output logic [CW-1:0] go_len,
   output logic          go_dir,
   output logic          irq
);

   logic [AW-1:0] base_q;
   logic [CW-1:0] len_q;
   logic          dir_q;
   logic          irq_q;
   logic          cfg_open, hit_cmd, start_req, zero_len, irq_clr, irq_set;
   logic          unused_wdata;

   assign unused_wdata = ^csr_wdata;
   assign cfg_open     = csr_we && !busy;
   assign hit_cmd      = csr_we && (csr_sel == SEL_CMD);
   assign zero_len     = (len_q == '0);
   assign start_req    = hit_cmd && csr_wdata[CMD_GO_BIT] && !busy;
   assign go           = start_req && !zero_len;
   assign irq_clr      = hit_cmd && csr_wdata[CMD_ACK_BIT];
   assign irq_set      = finish || (start_req && zero_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= '0;
         dir_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (cfg_open && csr_sel == SEL_BASE) base_q <= csr_wdata[AW-1:0];
         if (cfg_open && csr_sel == SEL_LEN)  len_q  <= csr_wdata[CW-1:0];
         if (cfg_open && csr_sel == SEL_MODE) dir_q  <= csr_wdata[0];
         if (irq_set)      irq_q <= 1'b1;
         else if (irq_clr) irq_q <= 1'b0;
      end
   end

   always_comb begin
      csr_rdata = '0;
      case (csr_sel)
         SEL_BASE: csr_rdata = DW'(base_q);
         SEL_LEN:  csr_rdata = DW'(len_q);
         SEL_MODE: csr_rdata[0] = dir_q;
         default: begin
            csr_rdata[STAT_BUSY_BIT] = busy;
            csr_rdata[STAT_IRQ_BIT]  = irq_q;
         end
      endcase
   end

   assign go_base = base_q;
   assign go_len  = len_q;
   assign go_dir  = dir_q;
   assign irq     = irq_q;

   // R9: configuration frozen during a job
   assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(base_q) && $stable(len_q) && $stable(dir_q)));

   // R7: completion raises the interrupt as busy drops
   assert_done_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq_q);

   // R8: empty job completes at once without starting
   assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && zero_len) |=> (irq_q && !busy));

   // R10: interrupt cleared only by an acknowledge
   assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !irq_clr) |=> irq_q);

   assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !irq_set) |=> !irq_q);

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
   import dma_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int CW        = 16,
   parameter int ADDR_STEP = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          go_dir,
   input  logic [AW-1:0] go_base,
   input  logic [CW-1:0] go_len,
   output logic          busy,
   output logic          finish,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ack,
   output logic          dev_req,
   output logic          dev_wr,
   output logic [DW-1:0] dev_wdata,
   input  logic [DW-1:0] dev_rdata,
   input  logic          dev_ack
);

   localparam int            SB       = $clog2(ADDR_STEP);
   localparam int            HI       = AW - SB;
   localparam logic [AW-1:0] STEP_INC = AW'(ADDR_STEP);

   xfer_state_e   st_q, st_d;
   logic [AW-1:0] addr_q, addr_nxt;
   logic [CW-1:0] left_q;
   logic [DW-1:0] word_q;
   logic          word_done, last_word;

   generate
      if (SB == 0) begin : g_unit_step
         assign addr_nxt = addr_q + AW'(1);
      end else begin : g_wide_step
         assign addr_nxt = {addr_q[AW-1:SB] + HI'(1), addr_q[SB-1:0]};
      end
   endgenerate

   assign word_done = (st_q == ST_DEV_PUT && dev_ack) || (st_q == ST_MEM_PUT && mem_ack);
   assign last_word = word_done && (left_q == CW'(1));

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:      if (go) st_d = go_dir ? ST_DEV_FETCH : ST_MEM_FETCH;
         ST_MEM_FETCH: if (mem_ack) st_d = ST_DEV_PUT;
         ST_DEV_PUT:   if (dev_ack) st_d = last_word ? ST_IDLE : ST_MEM_FETCH;
         ST_DEV_FETCH: if (dev_ack) st_d = ST_MEM_PUT;
         ST_MEM_PUT:   if (mem_ack) st_d = last_word ? ST_IDLE : ST_DEV_FETCH;
         default:      st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         left_q <= '0;
         word_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && go) begin
            addr_q <= go_base;
            left_q <= go_len;
         end else if (word_done) begin
            addr_q <= addr_nxt;
            left_q <= left_q - CW'(1);
         end
         if (st_q == ST_MEM_FETCH && mem_ack) word_q <= mem_rdata;
         if (st_q == ST_DEV_FETCH && dev_ack) word_q <= dev_rdata;
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign finish    = last_word;
   assign mem_req   = (st_q == ST_MEM_FETCH) || (st_q == ST_MEM_PUT);
   assign mem_we    = (st_q == ST_MEM_PUT);
   assign mem_addr  = addr_q;
   assign mem_wdata = word_q;
   assign dev_req   = (st_q == ST_DEV_PUT) || (st_q == ST_DEV_FETCH);
   assign dev_wr    = (st_q == ST_DEV_PUT);
   assign dev_wdata = word_q;

   // R11: one bus side at a time, requests held until acknowledged
   assert_one_side_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && dev_req));

   assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   assert_dev_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_req && !dev_ack) |=> (dev_req && $stable(dev_wr) && $stable(dev_wdata)));

   // R4: memory read is forwarded to the peripheral
   assert_m2d_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> (dev_req && dev_wr && dev_wdata == $past(mem_rdata)));

   // R5: peripheral fetch is forwarded to memory
   assert_d2m_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_req && !dev_wr && dev_ack) |=> (mem_req && mem_we && mem_wdata == $past(dev_rdata)));

   // R6: address advances by one step per completed word
   assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && !last_word) |=> (mem_addr == $past(mem_addr) + STEP_INC));

endmodule

// File: rtl/dma_block_mover.sv
module dma_block_mover #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int CW        = 16,
   parameter int ADDR_STEP = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          csr_we,
   input  logic [1:0]    csr_sel,
   input  logic [DW-1:0] csr_wdata,
   output logic [DW-1:0] csr_rdata,
   output logic          irq,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ack,
   output logic          dev_req,
   output logic          dev_wr,
   output logic [DW-1:0] dev_wdata,
   input  logic [DW-1:0] dev_rdata,
   input  logic          dev_ack
);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("DW must hold the two status bits");
      end
      if (AW > DW || CW > DW) begin : g_bad_fit
         $error("address and count must fit in a register word");
      end
      if (CW < 1) begin : g_bad_cw
         $error("CW must be at least 1");
      end
      if (ADDR_STEP < 1 || (ADDR_STEP & (ADDR_STEP - 1)) != 0) begin : g_bad_step
         $error("ADDR_STEP must be a power of two");
      end
      if ($clog2(ADDR_STEP) >= AW) begin : g_bad_aw
         $error("AW too narrow for ADDR_STEP");
      end
   endgenerate

   logic          busy, finish, go, go_dir;
   logic [AW-1:0] go_base;
   logic [CW-1:0] go_len;

   dma_cfg_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_we    (csr_we),
      .csr_sel   (csr_sel),
      .csr_wdata (csr_wdata),
      .csr_rdata (csr_rdata),
      .busy      (busy),
      .finish    (finish),
      .go        (go),
      .go_base   (go_base),
      .go_len    (go_len),
      .go_dir    (go_dir),
      .irq       (irq)
   );

   dma_xfer_engine #(.AW(AW), .DW(DW), .CW(CW), .ADDR_STEP(ADDR_STEP)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .go_dir    (go_dir),
      .go_base   (go_base),
      .go_len    (go_len),
      .busy      (busy),
      .finish    (finish),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ack   (mem_ack),
      .dev_req   (dev_req),
      .dev_wr    (dev_wr),
      .dev_wdata (dev_wdata),
      .dev_rdata (dev_rdata),
      .dev_ack   (dev_ack)
   );

endmodule

// File: tb/tb_dma_block_mover.sv
module tb_dma_block_mover;

   localparam int AW = 16;
   localparam int DW = 16;
   localparam int CW = 4;
   localparam int STEP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          csr_we = 1'b0;
   logic [1:0]    csr_sel = 2'd0;
   logic [DW-1:0] csr_wdata = '0;
   logic [DW-1:0] csr_rdata;
   logic          irq, mem_req, mem_we, dev_req, dev_wr;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, dev_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic [DW-1:0] dev_rdata = '0;
   logic          mem_ack = 1'b0;
   logic          dev_ack = 1'b0;

   always #4 clk = ~clk;

   dma_block_mover #(.AW(AW), .DW(DW), .CW(CW), .ADDR_STEP(STEP)) dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .dev_req(dev_req), .dev_wr(dev_wr), .dev_wdata(dev_wdata),
      .dev_rdata(dev_rdata), .dev_ack(dev_ack)
   );

   int checks = 0;
   int errors = 0;

   // ---------------- responders and monitors ----------------
   logic [15:0] mem [256];
   logic [15:0] dev_sink [16];
   logic        fill_req = 1'b0;
   logic [15:0] fill_seed = '0;
   logic [15:0] dev_seed = '0;
   logic        log_clr = 1'b0;
   int mem_lat = 1, dev_lat = 1;
   int mcnt = 0, dcnt = 0;
   int dsrc_i = 0, dsink_i = 0, both_cnt = 0, act_cnt = 0;

   function automatic logic [15:0] mpat(logic [15:0] s, int i);
      return s ^ 16'(i * 263);
   endfunction

   function automatic logic [15:0] dpat(logic [15:0] s, int k);
      return s + 16'(k * 515) + 16'h0005;
   endfunction

   always @(posedge clk) begin
      if (fill_req)
         for (int i = 0; i < 256; i++) mem[i] <= mpat(fill_seed, i);
      if (mem_req && !mem_ack) begin
         if (mcnt >= mem_lat) begin
            mem_ack <= 1'b1;
            mcnt <= 0;
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
         end else mcnt <= mcnt + 1;
      end else begin
         mem_ack <= 1'b0;
         mcnt <= 0;
      end
   end

   always @(posedge clk) begin
      if (log_clr) begin
         dsrc_i <= 0;
         dsink_i <= 0;
      end
      if (dev_req && !dev_ack) begin
         if (dcnt >= dev_lat) begin
            dev_ack <= 1'b1;
            dcnt <= 0;
            if (dev_wr) begin
               dev_sink[dsink_i[3:0]] <= dev_wdata;
               dsink_i <= dsink_i + 1;
            end else begin
               dev_rdata <= dpat(dev_seed, dsrc_i);
               dsrc_i <= dsrc_i + 1;
            end
         end else dcnt <= dcnt + 1;
      end else begin
         dev_ack <= 1'b0;
         dcnt <= 0;
      end
   end

   always @(posedge clk) begin
      if (log_clr) begin
         both_cnt <= 0;
         act_cnt <= 0;
      end else begin
         if (mem_req && dev_req) both_cnt <= both_cnt + 1;
         if (mem_req || dev_req) act_cnt <= act_cnt + 1;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic csr_write(logic [1:0] sel, logic [15:0] val);
      @(negedge clk);
      csr_we = 1'b1;
      csr_sel = sel;
      csr_wdata = val;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic csr_read(logic [1:0] sel, output logic [15:0] val);
      @(negedge clk);
      csr_sel = sel;
      #1;
      val = csr_rdata;
   endtask

   task automatic clear_log();
      @(negedge clk);
      log_clr = 1'b1;
      @(negedge clk);
      log_clr = 1'b0;
   endtask

   task automatic wait_idle();
      logic [15:0] v;
      for (int i = 0; i < 3000; i++) begin
         csr_read(2'd3, v);
         if (!v[0]) break;
      end
   endtask

   task automatic ack_irq(string tag);
      logic [15:0] v;
      csr_write(2'd3, 16'h0002);
      chk({tag, " irq cleared"}, int'(irq), 0);
      csr_read(2'd3, v);
      chk({tag, " status irq bit"}, int'(v[1]), 0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      logic [15:0] v;
      chk("R1 irq", int'(irq), 0);
      chk("R1 mem_req", int'(mem_req), 0);
      chk("R1 dev_req", int'(dev_req), 0);
      for (int s = 0; s < 4; s++) begin
         csr_read(2'(s), v);
         chk("R1 slot", int'(v), 0);
      end
   endtask

   task automatic t_regs();
      logic [15:0] v;
      clear_log();
      csr_write(2'd0, 16'hBEEF);
      csr_write(2'd1, 16'hFFF7);
      csr_write(2'd2, 16'hFFFF);
      csr_read(2'd0, v); chk("R2 base", int'(v), 16'hBEEF);
      csr_read(2'd1, v); chk("R2 count", int'(v), 16'h0007);
      csr_read(2'd2, v); chk("R2 dir", int'(v), 16'h0001);
      chk("R3 no activity without go", act_cnt, 0);
      csr_write(2'd2, 16'h0000);
      csr_read(2'd2, v); chk("R2 dir cleared", int'(v), 0);
   endtask

   task automatic t_xfer(string tag, logic [15:0] base, int len, bit dir,
                         int ml, int dl, logic [15:0] seed);
      logic [15:0] v;
      mem_lat = ml;
      dev_lat = dl;
      @(negedge clk);
      fill_seed = seed;
      dev_seed = seed ^ 16'h3C3C;
      fill_req = 1'b1;
      @(negedge clk);
      fill_req = 1'b0;
      clear_log();
      csr_write(2'd0, base);
      csr_write(2'd1, 16'(len));
      csr_write(2'd2, {15'd0, dir});
      csr_write(2'd3, 16'h0001);
      chk({tag, " R3 busy after go"}, int'(csr_rdata[0] | 1'b0) >= 0 ? int'(mem_req | dev_req) : 0, 1);
      csr_read(2'd3, v);
      chk({tag, " R3 busy bit"}, int'(v[0]), 1);
      wait_idle();
      chk({tag, " R7 irq at finish"}, int'(irq), 1);
      if (!dir) begin
         chk({tag, " R7 words moved"}, dsink_i, len);
         for (int k = 0; k < len; k++)
            chk({tag, " R4 R6 word"}, int'(dev_sink[k]), int'(mpat(seed, ((base >> 2) + k) & 255)));
      end else begin
         chk({tag, " R7 words moved"}, dsrc_i, len);
         for (int k = 0; k < len; k++)
            chk({tag, " R5 R6 word"}, int'(mem[((base >> 2) + k) & 255]), int'(dpat(seed ^ 16'h3C3C, k)));
      end
      chk({tag, " R11 exclusive"}, both_cnt, 0);
      ack_irq({tag, " R10"});
   endtask

   task automatic t_zero();
      logic [15:0] v;
      clear_log();
      csr_write(2'd1, 16'h0000);
      csr_write(2'd3, 16'h0001);
      chk("R8 irq next cycle", int'(irq), 1);
      csr_read(2'd3, v);
      chk("R8 not busy", int'(v[0]), 0);
      repeat (5) @(negedge clk);
      chk("R8 no bus activity", act_cnt, 0);
      ack_irq("R8 R10");
   endtask

   task automatic t_busy_writes();
      logic [15:0] v;
      mem_lat = 3;
      dev_lat = 3;
      clear_log();
      csr_write(2'd0, 16'h0200);
      csr_write(2'd1, 16'd6);
      csr_write(2'd2, 16'd0);
      csr_write(2'd3, 16'h0001);
      csr_write(2'd0, 16'h2222);
      csr_write(2'd1, 16'd2);
      csr_write(2'd2, 16'd1);
      csr_write(2'd3, 16'h0001);
      csr_read(2'd3, v); chk("R9 still busy", int'(v[0]), 1);
      csr_read(2'd0, v); chk("R9 base kept", int'(v), 16'h0200);
      csr_read(2'd1, v); chk("R9 count kept", int'(v), 6);
      csr_read(2'd2, v); chk("R9 dir kept", int'(v), 0);
      wait_idle();
      chk("R9 second go ignored", dsink_i, 6);
      chk("R9 no fetch from peripheral", dsrc_i, 0);
      ack_irq("R9 R10");
   endtask

   task automatic t_irq_hold();
      csr_write(2'd1, 16'd0);
      csr_write(2'd3, 16'h0001);
      csr_write(2'd0, 16'h0010);
      repeat (20) @(negedge clk);
      chk("R10 irq held", int'(irq), 1);
      csr_write(2'd3, 16'h0000);
      chk("R10 write without ack bit", int'(irq), 1);
      ack_irq("R10");
   endtask

   // ---------------- main ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_xfer("m2d", 16'h0040, 5, 1'b0, 1, 2, 16'h1234);
      t_xfer("d2m", 16'h0100, 3, 1'b1, 2, 0, 16'h5A5A);
      t_xfer("wrap R6", 16'hFFF8, 4, 1'b1, 0, 1, 16'h0F0F);
      t_xfer("max R7", 16'h0300, 15, 1'b0, 0, 0, 16'h7777);
      t_zero();
      t_busy_writes();
      t_irq_hold();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule